// File: doc/BRIEF.md
# Multicycle Register-File Processor Core

This block is a small processor core that runs one instruction at a time through separate micro-steps: three fetch steps, a decode step and one or more execute steps. It holds four 16-bit data registers, a program counter, an instruction register and an address/data register pair that faces a single shared memory port. The port has an 8-bit address, 16-bit read and write data, a read strobe and a one-cycle write strobe.

Each micro-step lasts a fixed, parameterised number of clock cycles. The defaults are 1 for a register transfer, 2 for decode, 2 for add or subtract, 5 for multiply and 10 for a memory access. Every instruction therefore has a fixed latency that can be predicted exactly. A one-cycle completion pulse marks the end of each instruction. A stop instruction parks the core in a halted state, and only reset leaves that state.

Top module: `mc_core`

## Requirements
- R1: A synchronous active-low reset clears the program counter, the four data registers, the address register and the data register to zero. While reset is held, `halted`, `instr_done`, `mem_rd` and `mem_wr` are low and `mem_addr` is 0. The first fetch after reset reads address 0.
- R2: The core fetches instructions from the program-counter address and puts that address on `mem_addr` during the fetch read. After each fetch the program counter advances by 2, so the k-th instruction after reset is fetched from address 2k.
- R3: Micro-step costs are: register transfer 1 cycle, decode 2, add or subtract 2, multiply 5, memory access 10. Fetch (address copy, memory read, instruction-register load) therefore takes 12 cycles. Total latencies, counted from the first fetch cycle to the completion pulse inclusive, are:
  - register move, stop and undefined opcodes: 15
  - load and store: 26
  - register add and register subtract: 16
  - memory add and memory subtract: 27
  - multiply: 19
- R4: Instruction encoding: opcode in bits 15:12, destination register in bits 11:10, source register in bits 9:8, memory address in bits 7:0. Opcode 0x0 is a register move: Dd <= Ds.
- R5: Opcode 0x1 loads memory into a register: Dd <= M[addr]. Opcode 0x2 stores a register to memory: M[addr] <= Ds. A store asserts `mem_wr` for exactly one cycle, in the last cycle of its 10-cycle access. No other instruction asserts `mem_wr`. `mem_rd` and `mem_wr` are never high together.
- R6: Opcodes 0x3 (Dd <= Dd + Ds) and 0x4 (Dd <= Dd + M[addr]) add. Opcodes 0x5 (Dd <= Dd - Ds) and 0x6 (Dd <= Dd - M[addr]) subtract. All results wrap modulo 2^16.
- R7: Opcode 0x7 multiplies: Dd <= low 16 bits of Dd * Ds.
- R8: Opcode 0xF stops the core. `halted` rises in the cycle after its completion pulse and stays high until reset. While halted, no memory read or write occurs, no completion pulse is given and `mem_addr` stays constant. Instructions placed after the stop are never executed.
- R9: Opcodes 0x8 to 0xE are no-operations: they change no register or memory and complete in 15 cycles.
- R10: `instr_done` is a one-cycle pulse in the last cycle of each instruction, given exactly once per executed instruction, including the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 8 | Memory address, driven from the address register |
| mem_rd | output | 1 | High during every cycle of a memory read access |
| mem_wr | output | 1 | One-cycle write strobe at the end of a store access |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data, sampled in the last cycle of a read access |
| instr_done | output | 1 | One-cycle pulse in the final cycle of each instruction |
| halted | output | 1 | High once a stop instruction has completed |

## Verification
The hardest state to reach from the ports is register contents. The data registers have no port of their own, so every wrapped sum, difference and truncated product becomes visible only when a later store writes it to memory. Each program, whether directed or random, ends with stores of all four registers, followed by a stop and then a further store that must never execute. The bench replays the same program in its own model. It then compares every data word, the latency of each instruction, the per-instruction write count and each fetch address.

// File: rtl/mc_pkg.sv
// Package: shared micro-step and ALU types, plus the opcode values.
// Assumes a 4-bit opcode field at the top of the instruction word.
package mc_pkg;

    typedef enum logic [3:0] {
        ST_F_MAR,   // address register <= program counter
        ST_F_RD,    // data register <= memory
        ST_F_IR,    // instruction register <= data register, pc += 2
        ST_DEC,     // decode
        ST_X_MAR,   // address register <= address field
        ST_X_RD,    // data register <= memory
        ST_X_LDMDR, // data register <= source register
        ST_X_WR,    // memory <= data register
        ST_X_WB,    // destination <= data register
        ST_X_ALU,   // destination <= ALU result
        ST_X_MOV,   // destination <= source register
        ST_X_NOP,   // undefined opcode, no effect
        ST_X_STOP,  // stop
        ST_HALT     // parked until reset
    } step_e;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} alu_e;

    localparam logic [3:0] OP_MOVR = 4'h0;
    localparam logic [3:0] OP_LD   = 4'h1;
    localparam logic [3:0] OP_ST   = 4'h2;
    localparam logic [3:0] OP_ADDR = 4'h3;
    localparam logic [3:0] OP_ADDM = 4'h4;
    localparam logic [3:0] OP_SUBR = 4'h5;
    localparam logic [3:0] OP_SUBM = 4'h6;
    localparam logic [3:0] OP_MUL  = 4'h7;
    localparam logic [3:0] OP_STOP = 4'hF;

endpackage

// File: rtl/mc_alu.sv
// Module: combinational arithmetic unit.
// Assumes results wrap to DW bits; the multiply keeps the low DW bits.
module mc_alu #(
    parameter int DW = 16
) (
    input  mc_pkg::alu_e  op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    import mc_pkg::*;

    // Select the arithmetic result for the requested operation.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/mc_regfile.sv
// Module: data register file with two read ports and one write port.
// Assumes NREG is a power of two; the write takes effect at the clock edge.
module mc_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [DW-1:0]           rdata_a,
    output logic [DW-1:0]           rdata_b
);
    localparam int RW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Hold one data register; clear it on reset, load it on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == RW'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mc_seq.sv
// Module: micro-step sequencer.
// Holds each step for its parameterised cycle count and picks the next
// step from the opcode. Assumes the opcode is stable from decode onward.
module mc_seq #(
    parameter int T_XFER = 1,
    parameter int T_DEC  = 2,
    parameter int T_ADD  = 2,
    parameter int T_MUL  = 5,
    parameter int T_MEM  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    opcode,
    output mc_pkg::step_e step,
    output logic          step_last,
    output logic          instr_end
);
    import mc_pkg::*;

    localparam int T_M1  = (T_XFER > T_DEC) ? T_XFER : T_DEC;
    localparam int T_M2  = (T_ADD > T_MUL) ? T_ADD : T_MUL;
    localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX = (T_M3 > T_MEM) ? T_M3 : T_MEM;
    localparam int CW    = $clog2(T_MAX + 1);

    logic [CW-1:0] cnt;
    int            dur;
    step_e         nxt;

    // Cycle count owed to the current step.
    always_comb begin
        case (step)
            ST_F_RD, ST_X_RD, ST_X_WR: dur = T_MEM;
            ST_DEC:                    dur = T_DEC;
            ST_X_ALU:                  dur = (opcode == OP_MUL) ? T_MUL : T_ADD;
            default:                   dur = T_XFER;
        endcase
    end

    assign step_last = (step != ST_HALT) && (int'(cnt) == dur - 1);

    // Step that follows the current one.
    always_comb begin
        case (step)
            ST_F_MAR: nxt = ST_F_RD;
            ST_F_RD:  nxt = ST_F_IR;
            ST_F_IR:  nxt = ST_DEC;
            ST_DEC: begin
                case (opcode)
                    OP_MOVR:                      nxt = ST_X_MOV;
                    OP_LD, OP_ST, OP_ADDM, OP_SUBM: nxt = ST_X_MAR;
                    OP_ADDR, OP_SUBR, OP_MUL:     nxt = ST_X_ALU;
                    OP_STOP:                      nxt = ST_X_STOP;
                    default:                      nxt = ST_X_NOP;
                endcase
            end
            ST_X_MAR:            nxt = (opcode == OP_ST) ? ST_X_LDMDR : ST_X_RD;
            ST_X_RD:             nxt = (opcode == OP_LD) ? ST_X_WB : ST_X_ALU;
            ST_X_LDMDR:          nxt = ST_X_WR;
            ST_X_STOP, ST_HALT:  nxt = ST_HALT;
            default:             nxt = ST_F_MAR;
        endcase
    end

    // Advance the cycle counter, and move on to the next step when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_F_MAR;
            cnt  <= '0;
        end else if (step_last) begin
            step <= nxt;
            cnt  <= '0;
        end else if (step != ST_HALT) begin
            cnt  <= cnt + 1'b1;
        end
    end

    assign instr_end = step_last &&
                       (step == ST_X_WR  || step == ST_X_WB  || step == ST_X_ALU ||
                        step == ST_X_MOV || step == ST_X_NOP || step == ST_X_STOP);
endmodule

// File: rtl/mc_core.sv
// Module: top of the multicycle core.
// Runs fetch/decode/execute micro-steps against one memory port. Assumes the
// memory returns read data combinationally and holds it for the whole access;
// the data is sampled in the access's last cycle.
module mc_core #(
    parameter int DW     = 16,
    parameter int AW     = 8,
    parameter int NREG   = 4,
    parameter int T_XFER = 1,
    parameter int T_DEC  = 2,
    parameter int T_ADD  = 2,
    parameter int T_MUL  = 5,
    parameter int T_MEM  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          instr_done,
    output logic          halted
);
    import mc_pkg::*;

    localparam int OPW = 4;
    localparam int RW  = $clog2(NREG);

    logic [AW-1:0] pc, mar;
    logic [DW-1:0] ir, mdr;
    step_e         step;
    logic          step_last, instr_end;

    logic [OPW-1:0] opcode;
    logic [RW-1:0]  dst, src;
    logic [DW-1:0]  rf_a, rf_b, alu_b, alu_y, rf_wdata;
    logic           rf_we, mem_form;
    alu_e           alu_op;

    assign opcode = ir[DW-1 -: OPW];
    assign dst    = ir[DW-OPW-1 -: RW];
    assign src    = ir[DW-OPW-RW-1 -: RW];

    mc_seq #(
        .T_XFER(T_XFER), .T_DEC(T_DEC), .T_ADD(T_ADD), .T_MUL(T_MUL), .T_MEM(T_MEM)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .step(step), .step_last(step_last), .instr_end(instr_end)
    );

    mc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(dst), .wdata(rf_wdata),
        .raddr_a(dst), .raddr_b(src), .rdata_a(rf_a), .rdata_b(rf_b)
    );

    // Decode the ALU operation and select its second operand.
    always_comb begin
        mem_form = (opcode == OP_ADDM) || (opcode == OP_SUBM);
        case (opcode)
            OP_SUBR, OP_SUBM: alu_op = ALU_SUB;
            OP_MUL:           alu_op = ALU_MUL;
            default:          alu_op = ALU_ADD;
        endcase
        alu_b = mem_form ? mdr : rf_b;
    end

    mc_alu #(.DW(DW)) u_alu (.op(alu_op), .a(rf_a), .b(alu_b), .y(alu_y));

    // Register-file write-back at the end of each writing step.
    always_comb begin
        rf_we = step_last && (step == ST_X_WB || step == ST_X_ALU || step == ST_X_MOV);
        case (step)
            ST_X_WB:  rf_wdata = mdr;
            ST_X_MOV: rf_wdata = rf_b;
            default:  rf_wdata = alu_y;
        endcase
    end

    // Datapath register transfers, each taking effect in the last cycle of its step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            ir  <= '0;
            mdr <= '0;
        end else if (step_last) begin
            case (step)
                ST_F_MAR:         mar <= pc;
                ST_F_RD, ST_X_RD: mdr <= mem_rdata;
                ST_F_IR: begin
                    ir <= mdr;
                    pc <= pc + AW'(2);
                end
                ST_X_MAR:         mar <= ir[AW-1:0];
                ST_X_LDMDR:       mdr <= rf_b;
                default: ;
            endcase
        end
    end

    assign mem_addr   = mar;
    assign mem_wdata  = mdr;
    assign mem_rd     = (step == ST_F_RD) || (step == ST_X_RD);
    assign mem_wr     = step_last && (step == ST_X_WR);
    assign instr_done = instr_end;
    assign halted     = (step == ST_HALT);
endmodule

// File: rtl/mc_core_sva.sv
// Module: property checker for mc_core, attached by bind.
// Assumes the default micro-step costs unless they are overridden.
module mc_core_sva #(
    parameter int AW     = 8,
    parameter int T_XFER = 1,
    parameter int T_DEC  = 2,
    parameter int T_MEM  = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          instr_done,
    input logic          halted
);
    localparam int MIN_INSTR = 3 * T_XFER + T_MEM + T_DEC;

    int rd_run;
    int gap;

    // Count the length of the current read strobe, and the cycles since the last completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_run <= 0;
            gap    <= 0;
        end else begin
            rd_run <= mem_rd ? rd_run + 1 : 0;
            if (instr_done)
                gap <= 0;
            else if (gap < MIN_INSTR)
                gap <= gap + 1;
        end
    end

    p_rw_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !mem_wr && !instr_done));
    p_halt_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);
    p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (rd_run < T_MEM));
    p_done_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (gap >= MIN_INSTR - 1));
endmodule

bind mc_core mc_core_sva u_sva (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .instr_done(instr_done), .halted(halted)
);

// File: tb/mc_core_bench.sv
// Bench: runs directed and random programs against a bench memory model and
// compares latencies, fetch addresses, write counts and final memory contents.
module mc_core_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr, instr_done, halted;
    logic [15:0] mem_wdata, mem_rdata;

    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    logic [15:0] mem [256];
    logic [15:0] img [256];
    logic [15:0] mdl [256];
    logic [15:0] prog [64];
    int          exp_lat [64];
    int          exp_wr [64];
    int          n_prog;

    int  checks = 0, fails = 0;
    bit  mon_on = 1'b0;
    int  cyc, wr_cnt, idx, wd = 0;
    bit  fa_seen;

    always #2 clk = ~clk;

    mc_core u_mc_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .instr_done(instr_done), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr];

    // Bench memory: loaded by the bench during reset, written by the core otherwise.
    always @(posedge clk) begin
        if (ld_en)
            mem[ld_addr] <= ld_data;
        else if (mem_wr)
            mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input int d, input int s, input int a);
        return {op, 2'(d), 2'(s), 8'(a)};
    endfunction

    function automatic int lat_of(input logic [3:0] op);
        case (op)
            4'h0:       return 15;
            4'h1, 4'h2: return 26;
            4'h3, 4'h5: return 16;
            4'h4, 4'h6: return 27;
            4'h7:       return 19;
            default:    return 15;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL R10 watchdog: cycles=%0d expected<150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Port monitor: per-instruction latency (R3), fetch address (R2), write count (R5), halt quietness (R8).
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            cyc++;
            if (mem_wr) wr_cnt++;
            if (halted) chk(!mem_wr && !mem_rd && !instr_done, "R8 quiet while halted", {mem_wr, mem_rd, instr_done}, 0);
            if (mem_rd && !fa_seen) begin
                fa_seen = 1'b1;
                chk(mem_addr == 8'(2 * idx), "R2 fetch address", mem_addr, 2 * idx);
            end
            if (instr_done) begin
                if (idx < n_prog) begin
                    chk(cyc == exp_lat[idx], "R3 instruction latency", cyc, exp_lat[idx]);
                    chk(wr_cnt == exp_wr[idx], "R5 write strobe count", wr_cnt, exp_wr[idx]);
                end else begin
                    chk(1'b0, "R10 extra completion pulse", idx, n_prog - 1);
                end
                idx++;
                cyc = 0;
                wr_cnt = 0;
                fa_seen = 1'b0;
            end
        end
    end

    // Replay the program in the bench model to get expected memory and latencies.
    task automatic model_run();
        logic [15:0] rf [4];
        for (int r = 0; r < 4; r++) rf[r] = '0;
        for (int a = 0; a < 256; a++) mdl[a] = img[a];
        for (int k = 0; k < n_prog; k++) begin
            logic [3:0] op;
            int d, s, a;
            op = prog[k][15:12];
            d = int'(prog[k][11:10]);
            s = int'(prog[k][9:8]);
            a = int'(prog[k][7:0]);
            exp_lat[k] = lat_of(op);
            exp_wr[k] = (op == 4'h2) ? 1 : 0;
            case (op)
                4'h0: rf[d] = rf[s];
                4'h1: rf[d] = mdl[a];
                4'h2: mdl[a] = rf[s];
                4'h3: rf[d] = rf[d] + rf[s];
                4'h4: rf[d] = rf[d] + mdl[a];
                4'h5: rf[d] = rf[d] - rf[s];
                4'h6: rf[d] = rf[d] - mdl[a];
                4'h7: rf[d] = rf[d] * rf[s];
                default: ;
            endcase
        end
    endtask

    // Build one program: mode 0 = stores only, 1 = directed corners, else random.
    task automatic build(input int mode);
        n_prog = 0;
        for (int a = 0; a < 256; a++) img[a] = '0;
        for (int a = 8'h80; a < 8'hF0; a++) img[a] = 16'($urandom);
        if (mode == 1) begin
            img[8'h80] = 16'hFFFF; img[8'h81] = 16'h0003; img[8'h82] = 16'h8000;
            prog[n_prog++] = mk(4'h1, 0, 0, 8'h80);   // R5 load D0
            prog[n_prog++] = mk(4'h1, 1, 0, 8'h81);   // R5 load D1
            prog[n_prog++] = mk(4'h3, 0, 1, 0);       // R6 wrap: FFFF+3
            prog[n_prog++] = mk(4'h5, 2, 1, 0);       // R6 wrap: 0-3
            prog[n_prog++] = mk(4'h7, 2, 2, 0);       // R7 low half of FFFD^2
            prog[n_prog++] = mk(4'h1, 3, 0, 8'h82);
            prog[n_prog++] = mk(4'h4, 3, 0, 8'h82);   // R6 8000+8000 wraps to 0
            prog[n_prog++] = mk(4'h6, 3, 0, 8'h81);   // R6 memory subtract
            prog[n_prog++] = mk(4'h0, 1, 0, 0);       // R4 move
            prog[n_prog++] = mk(4'hA, 1, 2, 8'hC7);   // R9 undefined opcode
            prog[n_prog++] = mk(4'h2, 0, 2, 8'hC5);   // R5 store
            prog[n_prog++] = mk(4'h1, 3, 0, 8'hC5);   // R5 load it back
            prog[n_prog++] = mk(4'hE, 3, 3, 8'hC6);   // R9 undefined opcode
        end else if (mode >= 2) begin
            for (int k = 0; k < 50; k++) begin
                int r, d, s;
                r = int'($urandom % 20);
                d = int'($urandom % 4);
                s = int'($urandom % 4);
                if (r < 3)       prog[n_prog++] = mk(4'h0, d, s, 0);
                else if (r < 6)  prog[n_prog++] = mk(4'h1, d, s, 8'h80 + $urandom % 8'h50);
                else if (r < 8)  prog[n_prog++] = mk(4'h2, d, s, 8'hC0 + $urandom % 16);
                else if (r < 10) prog[n_prog++] = mk(4'h3, d, s, 0);
                else if (r < 12) prog[n_prog++] = mk(4'h4, d, s, 8'h80 + $urandom % 8'h50);
                else if (r < 14) prog[n_prog++] = mk(4'h5, d, s, 0);
                else if (r < 16) prog[n_prog++] = mk(4'h6, d, s, 8'h80 + $urandom % 8'h50);
                else if (r < 19) prog[n_prog++] = mk(4'h7, d, s, 0);
                else             prog[n_prog++] = mk(4'(8 + $urandom % 7), d, s, $urandom % 256);
            end
        end
        for (int r = 0; r < 4; r++) prog[n_prog++] = mk(4'h2, 0, r, 8'hF0 + r);
        prog[n_prog++] = mk(4'hF, 0, 0, 0);
        for (int k = 0; k < n_prog; k++) img[2 * k] = prog[k];
        img[2 * n_prog] = mk(4'h2, 0, 0, 8'hF8);      // R8: must never run
        img[8'hF8] = 16'h5A5A;
    endtask

    task automatic run_round(input int mode);
        build(mode);
        model_run();
        @(posedge clk); #1 rst_n = 1'b0;
        for (int a = 0; a < 256; a++) begin
            ld_en = 1'b1; ld_addr = 8'(a); ld_data = img[a];
            @(posedge clk); #1;
        end
        ld_en = 1'b0;
        @(negedge clk);
        chk(!halted && !instr_done && !mem_rd && !mem_wr && mem_addr == 8'h00,
            "R1 reset outputs", {halted, instr_done, mem_rd, mem_wr, mem_addr}, 0);
        cyc = 0; wr_cnt = 0; idx = 0; fa_seen = 1'b0;
        mon_on = 1'b1;
        @(posedge clk); #1 rst_n = 1'b1;
        while (!halted) @(negedge clk);
        chk(idx == n_prog, "R10 completion count at halt", idx, n_prog);
        repeat (40) @(negedge clk);
        chk(halted == 1'b1, "R8 halt held", halted, 1);
        chk(idx == n_prog, "R8 no completion after stop", idx, n_prog);
        mon_on = 1'b0;
        for (int a = 8'h80; a < 256; a++)
            chk(mem[a] === mdl[a], (mode == 0) ? "R1 registers cleared" : "R4-R7 memory result",
                int'(mem[a]), int'(mdl[a]));
    endtask

    initial begin
        void'($urandom(32'h1C0DE5));
        run_round(0);
        run_round(1);
        for (int m = 2; m < 6; m++) run_round(m);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule